// File: doc/BRIEF.md
# Sleep Entry and Watchdog Status Controller

This block carries out the power-down instruction of a small 8-bit core and keeps the two status flags that say why the core last stopped. It runs a four-phase instruction cycle (phase 0 to phase 3). It looks at the fetched 16-bit instruction word in phase 0. When that word is the sleep opcode, it clears the watchdog and its postscaler in phase 2 and sets the time-out flag and clears the power-down flag. In phase 3 it drops a core clock enable, which stands in for stopping the oscillator.

The watchdog is a two-level counter. A base counter counts an always-on tick and feeds a postscaler. The watchdog keeps counting while the core sleeps. A watchdog time-out wakes a sleeping core and clears the time-out flag. An external wake request also restarts the core, but it leaves both flags as they are. A clear-watchdog request from the running core restarts the watchdog and sets both flags. The phase counter is frozen while the clock enable is low.

Top module: `sleep_wdt_ctrl`

## Requirements
- R1: After reset, the time-out flag is 1, the power-down flag is 1, the clock enable is 1, the phase is 0 and the expiry pulse is 0.
- R2: A sleep sequence starts only when the instruction word equals 16'h0003 while the phase is 0 and the clock is enabled. The same word seen in phases 1 to 3, or any other word in phase 0, has no effect.
- R3: In phase 2 of a sleep sequence, the watchdog and its postscaler are cleared, the time-out flag becomes 1 and the power-down flag becomes 0, all at the same clock edge.
- R4: At the clock edge that ends phase 3 of a sleep sequence, the clock enable goes to 0 and the phase returns to 0.
- R5: While the clock is enabled, the phase steps 0,1,2,3,0 on each clock. While the clock is disabled, the phase holds its value.
- R6: The watchdog times out on the WDT_PERIOD*POST_RATIO-th tick after its last clear. It then restarts from zero, wdt_expired pulses high for exactly one cycle after that tick, and the time-out flag is cleared. Ticks are counted whether the core is asleep or awake.
- R7: A time-out while the clock is disabled sets the clock enable back to 1, and the time-out flag reads 0.
- R8: A wake request while the clock is disabled sets the clock enable to 1 and leaves both flags unchanged. While the clock is enabled, a wake request has no effect.
- R9: A clear-watchdog request while the clock is enabled clears the watchdog and sets both flags to 1. While the clock is disabled, the request is ignored.
- R10: A watchdog clear in the same cycle as the tick that would expire the watchdog suppresses that time-out: there is no expiry pulse and the time-out flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous power-on reset |
| wdt_tick | input | 1 | Always-on watchdog count enable, one per tick |
| instr_word | input | 16 | Fetched instruction word |
| clrwdt_req | input | 1 | Clear-watchdog instruction request |
| wake_req | input | 1 | External or interrupt wake request |
| core_clk_en | output | 1 | Core clock enable; low while sleeping |
| q_phase | output | 2 | Current instruction-cycle phase |
| flag_to | output | 1 | Time-out status flag |
| flag_pd | output | 1 | Power-down status flag |
| wdt_expired | output | 1 | One-cycle watchdog expiry pulse |

## Verification
The main function is exercised with four patterns. The sleep opcode is placed only in phases 1 to 3, and a near-miss word is placed in phase 0; this separates correct phase-0 decoding from decoding in any phase or matching on only some bits. Sleep is then entered with ticks on every cycle and left to expire, which separates the time-out wake from an external wake, since the two differ in the final time-out flag. Sleep is also entered with sparse ticks and ended by a wake request. Finally, a clear is placed on the exact expiring tick, and clear requests are issued during sleep; these separate correct clear priority and gating from a clear that is always accepted or always loses.

// File: rtl/sleep_wdt_ctrl.sv
module sleep_wdt_ctrl #(
  parameter int WDT_PERIOD = 256,
  parameter int POST_RATIO = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wdt_tick,
  input  logic [15:0] instr_word,
  input  logic        clrwdt_req,
  input  logic        wake_req,
  output logic        core_clk_en,
  output logic [1:0]  q_phase,
  output logic        flag_to,
  output logic        flag_pd,
  output logic        wdt_expired
);
  localparam int CW = (WDT_PERIOD > 1) ? $clog2(WDT_PERIOD) : 1;
  localparam int PW = (POST_RATIO > 1) ? $clog2(POST_RATIO) : 1;
  localparam logic [15:0] SLEEP_OP = 16'h0003;

  logic [CW-1:0] wdt_cnt;
  logic [PW-1:0] post_cnt;
  logic          sleep_pend;

  wire sleep_exec  = core_clk_en && q_phase == 2'd2 && sleep_pend;
  wire sleep_go    = core_clk_en && q_phase == 2'd3 && sleep_pend;
  wire clr_req     = core_clk_en && clrwdt_req;
  wire wdt_clear   = sleep_exec || clr_req;
  wire cnt_last    = wdt_cnt == CW'(WDT_PERIOD - 1);
  wire post_last   = post_cnt == PW'(POST_RATIO - 1);
  wire timeout_evt = wdt_tick && !wdt_clear && cnt_last && post_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdt_cnt     <= '0;
      post_cnt    <= '0;
      wdt_expired <= 1'b0;
    end else begin
      wdt_expired <= timeout_evt;
      if (wdt_clear) begin
        wdt_cnt  <= '0;
        post_cnt <= '0;
      end else if (wdt_tick) begin
        wdt_cnt <= cnt_last ? '0 : wdt_cnt + 1'b1;
        if (cnt_last)
          post_cnt <= post_last ? '0 : post_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_to <= 1'b1;
      flag_pd <= 1'b1;
    end else if (sleep_exec) begin
      flag_to <= 1'b1;
      flag_pd <= 1'b0;
    end else if (clr_req) begin
      flag_to <= 1'b1;
      flag_pd <= 1'b1;
    end else if (timeout_evt) begin
      flag_to <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_clk_en <= 1'b1;
      q_phase     <= 2'd0;
      sleep_pend  <= 1'b0;
    end else if (core_clk_en) begin
      q_phase <= q_phase + 2'd1;
      if (q_phase == 2'd0)
        sleep_pend <= instr_word == SLEEP_OP;
      if (sleep_go) begin
        core_clk_en <= 1'b0;
        sleep_pend  <= 1'b0;
      end
    end else if (timeout_evt || wake_req) begin
      core_clk_en <= 1'b1;
    end
  end

  AST_SLEEP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_exec |=> flag_to && !flag_pd);  // R3
  AST_CLK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_go |=> !core_clk_en && q_phase == 2'd0);  // R4
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en |=> q_phase == 2'($past(q_phase) + 2'd1));  // R5
  AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en |=> $stable(q_phase));  // R5
  AST_EXPIRE_TO: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> wdt_expired && !flag_to);  // R6
  AST_WDT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en && timeout_evt |=> core_clk_en && !flag_to);  // R7
  AST_EXT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en && wake_req && !timeout_evt |=> core_clk_en && $stable(flag_to) && $stable(flag_pd));  // R8
  AST_CLRWDT: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !sleep_exec |=> flag_to && flag_pd && !wdt_expired);  // R9
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clear |=> !wdt_expired && flag_to);  // R10
endmodule

// File: tb/sleep_wdt_ctrl_bench.sv
`timescale 1ns/1ps
module sleep_wdt_ctrl_bench;
  localparam int P = 4;
  localparam int R = 3;

  logic clk = 1'b0, rst_n = 1'b0, wdt_tick = 1'b0, clrwdt_req = 1'b0, wake_req = 1'b0;
  logic [15:0] instr_word = 16'h1234;
  logic core_clk_en, flag_to, flag_pd, wdt_expired;
  logic [1:0] q_phase;

  int total = 0, bad = 0, cyc = 0, tick_div = 0;
  bit done = 0;
  int m_ph, m_ticks;
  bit m_en, m_to, m_pd, m_exp, m_pend;

  sleep_wdt_ctrl #(.WDT_PERIOD(P), .POST_RATIO(R)) u_sleep_wdt_ctrl (
    .clk(clk), .rst_n(rst_n), .wdt_tick(wdt_tick), .instr_word(instr_word),
    .clrwdt_req(clrwdt_req), .wake_req(wake_req), .core_clk_en(core_clk_en),
    .q_phase(q_phase), .flag_to(flag_to), .flag_pd(flag_pd), .wdt_expired(wdt_expired));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_ticks = 0; m_en = 1; m_to = 1; m_pd = 1; m_exp = 0; m_pend = 0;
    end else begin
      bit exec, clr, tmo;
      exec = m_en && m_ph == 2 && m_pend;
      clr  = exec || (m_en && clrwdt_req);
      tmo  = 0;
      if (clr) m_ticks = 0;
      else if (wdt_tick) begin
        m_ticks++;
        if (m_ticks == P * R) begin m_ticks = 0; tmo = 1; end
      end
      m_exp = tmo;
      if (exec) begin m_to = 1; m_pd = 0; end
      else if (m_en && clrwdt_req) begin m_to = 1; m_pd = 1; end
      else if (tmo) m_to = 0;
      if (m_en) begin
        if (m_ph == 0) m_pend = (instr_word == 16'h0003);
        if (m_ph == 3 && m_pend) begin m_en = 0; m_pend = 0; end
        m_ph = (m_ph + 1) % 4;
      end else if (tmo || wake_req) m_en = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    if (rst_n) begin
      chk(core_clk_en == m_en, "R4 clk_en", core_clk_en, m_en);
      chk(q_phase == 2'(m_ph), "R5 phase", q_phase, m_ph);
      chk(flag_to == m_to, "R3 flag_to", flag_to, m_to);
      chk(flag_pd == m_pd, "R3 flag_pd", flag_pd, m_pd);
      chk(wdt_expired == m_exp, "R6 expired", wdt_expired, m_exp);
    end
    if (tick_div != 0) wdt_tick = (cyc % tick_div) == 0;
  endtask

  task automatic do_sleep();
    while (m_ph != 0 || !m_en) step();
    instr_word = 16'h0003;
    step();
    instr_word = 16'h1234;
    repeat (3) step();
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    chk(flag_to && flag_pd && core_clk_en && q_phase == 0 && !wdt_expired,
        "R1 reset state", {flag_to, flag_pd, core_clk_en, q_phase, wdt_expired}, 6'b111000);
    for (int i = 0; i < 16; i++) begin
      step();
      instr_word = (m_ph != 0) ? 16'h0003 : ((i % 2) ? 16'h0103 : 16'h0007);
    end
    step();
    instr_word = 16'h1234;
    chk(core_clk_en == 1, "R2 no sleep from wrong phase/word", core_clk_en, 1);

    tick_div = 1;
    do_sleep();
    chk(core_clk_en == 0 && flag_pd == 0, "R4 asleep", core_clk_en, 0);
    for (int i = 0; i < 20 && !m_en; i++) step();
    chk(core_clk_en == 1 && flag_to == 0, "R7 timeout wake", flag_to, 0);

    clrwdt_req = 1; step(); clrwdt_req = 0;
    chk(flag_to && flag_pd, "R9 clear sets flags", {flag_to, flag_pd}, 3);

    tick_div = 3;
    do_sleep();
    repeat (4) step();
    wake_req = 1; step(); wake_req = 0;
    chk(core_clk_en == 1 && flag_to == 1 && flag_pd == 0, "R8 external wake",
        {core_clk_en, flag_to, flag_pd}, 3'b110);
    wake_req = 1; repeat (3) step(); wake_req = 0;
    chk(core_clk_en == 1, "R8 wake while awake", core_clk_en, 1);

    tick_div = 0; wdt_tick = 0;
    do_sleep();
    clrwdt_req = 1; step(); clrwdt_req = 0;
    chk(flag_pd == 0 && core_clk_en == 0, "R9 clear ignored asleep", flag_pd, 0);
    wake_req = 1; step(); wake_req = 0;

    clrwdt_req = 1; step(); clrwdt_req = 0;
    while (m_ticks != P * R - 1) begin wdt_tick = 1; step(); end
    wdt_tick = 1; clrwdt_req = 1; step();
    wdt_tick = 0; clrwdt_req = 0; step();
    chk(wdt_expired == 0 && flag_to == 1, "R10 clear beats timeout", {wdt_expired, flag_to}, 1);

    tick_div = 1;
    repeat (30) step();
    chk(flag_to == 0, "R6 awake timeout clears TO", flag_to, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule